// File: doc/BRIEF.md
# Masked Interrupt Request Collector

This block collects interrupt requests from the peripherals around an 8-bit microcontroller core and offers at most one of them to the CPU at a time. There are 18 sources, numbered 0 to 17. Each source has a sticky request flag, which is set when the source's request rises. A pending flag reaches the CPU only when two things are set: the per-source enable bit and the single global enable bit.

Sources 10 to 17 are built from eight events each. Every event has its own mask bit, and the source request is the OR of its unmasked events. Source 3 is shared by two peripherals: either of them raises its flag. Software reads and writes the enable, flag and event-mask registers over a simple 8-bit register bus.

A two-state machine hands requests to the CPU:
- ST_IDLE: no request is offered. If any enabled flag is pending, the machine takes the transition IDLE→OFFER and latches the lowest-numbered pending source.
- ST_OFFER: `irq_valid_o` is high and `irq_idx_o` is held. The machine takes the transition OFFER→IDLE (ack) when the CPU pulses `irq_ack_i`, which also clears the flag of the offered source. It takes the transition OFFER→IDLE (withdraw) when the offered source stops qualifying because its flag, its enable or the global enable has dropped.

Top module: `irq_gather`

## Requirements
- R1: A source's flag is set on the clock edge at which its request is sampled high after being low, and it stays set. Flags read back at address 3 (sources 0–7 in bits 0–7), address 4 (sources 8–15 in bits 0–7) and address 5 (sources 16–17 in bits 0–1).
- R2: Writing a flag register clears every flag whose data bit is 0. A data bit of 1 leaves that flag unchanged.
- R3: Per-source enables are at address 0 bits 5:0 (sources 0–5), address 1 bits 5:0 (sources 6–11) and address 2 bits 5:0 (sources 12–17). A pending flag whose enable is 0 is never offered.
- R4: The global enable is address 0 bit 7. While it is 0, `irq_valid_o` is 0 from the next cycle on.
- R5: Source 10+g (g = 0..7) requests when `grp_evt_i[8g+k]` and bit k of the mask register at address 8+g are both 1, for some k. The mask registers read back as written.
- R6: Source 3 requests when `src_line_i[3]` or `aud_req_i` is high. Sources 0–9 other than 3 follow `src_line_i` directly.
- R7: From ST_IDLE, the lowest-numbered enabled pending flag is offered on the next edge, with `irq_valid_o`=1 and its index on `irq_idx_o`.
- R8: While offered and not acknowledged, `irq_idx_o` does not change, even if a lower-numbered request arrives. If the offered source stops qualifying, the offer is withdrawn and arbitration restarts.
- R9: `irq_ack_i` sampled while `irq_valid_o`=1 clears the offered flag and drops `irq_valid_o` on that edge. `irq_ack_i` sampled while `irq_valid_o`=0 has no effect.
- R10: A request that rises on the same edge as a software clear or an acknowledge leaves the flag set.
- R11: Address 0 bit 6, address 1 bits 7:6, address 2 bits 7:6, address 5 bits 7:2, and addresses 6 and 7 read as 0. Writes to them have no effect.
- R12: After reset, all flags, enables and masks are 0 and `irq_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line_i | input | 10 | Request lines of sources 0–9 |
| aud_req_i | input | 1 | Second request line into source 3 |
| grp_evt_i | input | 64 | Eight events for each of sources 10–17 |
| reg_addr_i | input | 4 | Register address |
| reg_wen_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, with no side effects |
| irq_ack_i | input | 1 | CPU acknowledge of the offered source |
| irq_valid_o | output | 1 | A request is offered |
| irq_idx_o | output | 5 | Index of the offered source |

## Verification
The properties assume that all request, event and bus inputs are synchronous to `clk` and settle between edges. They also assume that `irq_ack_i` matters only in a cycle where `irq_valid_o` is high. The stimulus changes inputs one time unit after the rising edge and holds each request or acknowledge for whole cycles. Acknowledges are issued both during an offer and outside one, so the ignored case is covered as well. The race cases are set up deliberately: a request rises on the same edge as a flag-register write or an acknowledge.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
    localparam int NSRC        = 18;
    localparam int IDX_W       = 5;
    localparam int DW          = 8;
    localparam int AW          = 4;
    localparam int NGRP        = 8;
    localparam int EVW         = 8;
    localparam int GRP_BASE    = NSRC - NGRP;
    localparam int SHARED_SRC  = 3;
    localparam int SRC_PER_EN  = 6;
    localparam int N_EN_REG    = NSRC / SRC_PER_EN;
    localparam int A_FL0       = 3;
    localparam int N_FL_REG    = (NSRC + DW - 1) / DW;
    localparam int A_MSK       = 8;
    localparam int GLB_BIT     = DW - 1;

    typedef enum logic {
        ST_IDLE,
        ST_OFFER
    } offer_st_t;
endpackage

// File: rtl/irqg_regs.sv
module irqg_regs
    import irqg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic [NSRC-1:0]     flags,
    output logic [NSRC-1:0]     src_en,
    output logic                glb_en,
    output logic [NGRP*EVW-1:0] evt_mask,
    output logic [NSRC-1:0]     sw_clr,
    output logic [DW-1:0]       rd_data
);
    logic [NSRC-1:0]     en_q;
    logic                glb_q;
    logic [NGRP*EVW-1:0] msk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            glb_q <= 1'b0;
            msk_q <= '0;
        end else if (wr_en) begin
            if (int'(addr) < N_EN_REG) begin
                en_q[int'(addr)*SRC_PER_EN +: SRC_PER_EN] <= wdata[SRC_PER_EN-1:0];
                if (addr == '0) glb_q <= wdata[GLB_BIT];
            end else if (int'(addr) >= A_MSK) begin
                msk_q[(int'(addr)-A_MSK)*EVW +: EVW] <= wdata;
            end
        end
    end

    always_comb begin
        sw_clr = '0;
        if (wr_en && int'(addr) >= A_FL0 && int'(addr) < A_FL0 + N_FL_REG) begin
            for (int i = 0; i < NSRC; i++) begin
                if (i / DW == int'(addr) - A_FL0) sw_clr[i] = !wdata[i % DW];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(addr) < N_EN_REG) begin
            rd_data[SRC_PER_EN-1:0] = en_q[int'(addr)*SRC_PER_EN +: SRC_PER_EN];
            if (addr == '0) rd_data[GLB_BIT] = glb_q;
        end else if (int'(addr) < A_FL0 + N_FL_REG) begin
            for (int i = 0; i < NSRC; i++) begin
                if (i / DW == int'(addr) - A_FL0) rd_data[i % DW] = flags[i];
            end
        end else if (int'(addr) >= A_MSK) begin
            rd_data = msk_q[(int'(addr)-A_MSK)*EVW +: EVW];
        end
    end

    assign src_en   = en_q;
    assign glb_en   = glb_q;
    assign evt_mask = msk_q;
endmodule

// File: rtl/irqg_combine.sv
module irqg_combine
    import irqg_pkg::*;
(
    input  logic [GRP_BASE-1:0] src_line,
    input  logic                aud_req,
    input  logic [NGRP*EVW-1:0] grp_evt,
    input  logic [NGRP*EVW-1:0] evt_mask,
    output logic [NSRC-1:0]     src_req
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i >= GRP_BASE) begin : g_grp
            assign src_req[i] = |(grp_evt[(i-GRP_BASE)*EVW +: EVW] &
                                  evt_mask[(i-GRP_BASE)*EVW +: EVW]);
        end else if (i == SHARED_SRC) begin : g_shared
            assign src_req[i] = src_line[i] | aud_req;
        end else begin : g_line
            assign src_req[i] = src_line[i];
        end
    end
endmodule

// File: rtl/irqg_flags.sv
module irqg_flags
    import irqg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic [NSRC-1:0] sw_clr,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] flags
);
    logic [NSRC-1:0] req_prev;
    logic [NSRC-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= '0;
            flag_q   <= '0;
        end else begin
            req_prev <= src_req;
            flag_q   <= (flag_q & ~sw_clr & ~ack_clr) | (src_req & ~req_prev);
        end
    end

    assign flags = flag_q;
endmodule

// File: rtl/irqg_offer.sv
module irqg_offer
    import irqg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  flags,
    input  logic [NSRC-1:0]  src_en,
    input  logic             glb_en,
    input  logic             irq_ack,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_idx,
    output logic [NSRC-1:0]  ack_clr
);
    offer_st_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [NSRC-1:0]  pend;
    logic [IDX_W-1:0] win;
    logic             any;

    assign pend = flags & src_en & {NSRC{glb_en}};
    assign any  = |pend;

    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) win = IDX_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any) begin
                    state_d = ST_OFFER;
                    idx_d   = win;
                end
            end
            ST_OFFER: begin
                if (irq_ack || !pend[idx_q]) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        irq_valid = (state_q == ST_OFFER);
        irq_idx   = idx_q;
        for (int i = 0; i < NSRC; i++) begin
            ack_clr[i] = irq_valid && irq_ack && (idx_q == IDX_W'(i));
        end
    end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irqg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRP_BASE-1:0] src_line_i,
    input  logic                aud_req_i,
    input  logic [NGRP*EVW-1:0] grp_evt_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic                reg_wen_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    input  logic                irq_ack_i,
    output logic                irq_valid_o,
    output logic [IDX_W-1:0]    irq_idx_o
);
    logic [NSRC-1:0]     flag_q;
    logic [NSRC-1:0]     src_en;
    logic                glb_en;
    logic [NGRP*EVW-1:0] evt_mask;
    logic [NSRC-1:0]     sw_clr;
    logic [NSRC-1:0]     ack_clr;
    logic [NSRC-1:0]     src_req;

    irqg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wen_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .flags    (flag_q),
        .src_en   (src_en),
        .glb_en   (glb_en),
        .evt_mask (evt_mask),
        .sw_clr   (sw_clr),
        .rd_data  (reg_rdata_o)
    );

    irqg_combine u_comb (
        .src_line (src_line_i),
        .aud_req  (aud_req_i),
        .grp_evt  (grp_evt_i),
        .evt_mask (evt_mask),
        .src_req  (src_req)
    );

    irqg_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .sw_clr  (sw_clr),
        .ack_clr (ack_clr),
        .flags   (flag_q)
    );

    irqg_offer u_offer (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flag_q),
        .src_en    (src_en),
        .glb_en    (glb_en),
        .irq_ack   (irq_ack_i),
        .irq_valid (irq_valid_o),
        .irq_idx   (irq_idx_o),
        .ack_clr   (ack_clr)
    );
endmodule

// File: rtl/irqg_check.sv
module irqg_check
    import irqg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_valid,
    input logic [IDX_W-1:0] irq_idx,
    input logic             irq_ack,
    input logic [NSRC-1:0]  flags,
    input logic [NSRC-1:0]  src_en,
    input logic             glb_en
);
    logic [NSRC-1:0] flag_d;
    logic [NSRC-1:0] en_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_d <= '0;
            en_d   <= '0;
        end else begin
            flag_d <= flags;
            en_d   <= src_en;
        end
    end

    // R4: global enable low stops any offer on the next edge
    a_r4_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !irq_valid);

    // R8: offered index holds until acknowledged or withdrawn
    a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (!irq_valid || $stable(irq_idx)));

    // R9: acknowledge ends the offer
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> !irq_valid);

    // R7: a new offer names a source that was pending and enabled, with no lower one pending
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_valid) |-> (flag_d[irq_idx] && en_d[irq_idx] &&
            ((flag_d & en_d & ((NSRC'(1) << irq_idx) - NSRC'(1))) == '0)));
endmodule

bind irq_gather irqg_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_valid (irq_valid_o),
    .irq_idx   (irq_idx_o),
    .irq_ack   (irq_ack_i),
    .flags     (flag_q),
    .src_en    (src_en),
    .glb_en    (glb_en)
);

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src_line = '0;
    logic        aud_req = 1'b0;
    logic [63:0] grp_evt = '0;
    logic [3:0]  addr = '0;
    logic        wen = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ack = 1'b0;
    logic        valid;
    logic [4:0]  idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_gather u0 (
        .clk(clk), .rst_n(rst_n), .src_line_i(src_line), .aud_req_i(aud_req),
        .grp_evt_i(grp_evt), .reg_addr_i(addr), .reg_wen_i(wen),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_ack_i(ack),
        .irq_valid_o(valid), .irq_idx_o(idx)
    );

    // behavioural reference model
    bit       m_flag[18];
    bit       m_prev[18];
    bit       m_en[18];
    bit       m_gen;
    bit [7:0] m_mask[8];
    bit       m_off;
    int       m_idx;

    function automatic bit m_req(int s);
        if (s >= 10) return |(grp_evt[(s-10)*8 +: 8] & m_mask[s-10]);
        if (s == 3)  return src_line[3] | aud_req;
        return src_line[s];
    endfunction

    function automatic bit m_pend(int s);
        return m_flag[s] && m_en[s] && m_gen;
    endfunction

    function automatic logic [7:0] m_read(int a);
        logic [7:0] r = '0;
        if (a <= 2) begin
            for (int b = 0; b < 6; b++) r[b] = m_en[a*6 + b];
            if (a == 0) r[7] = m_gen;
        end else if (a <= 5) begin
            for (int b = 0; b < 8; b++) if ((a-3)*8 + b < 18) r[b] = m_flag[(a-3)*8 + b];
        end else if (a >= 8) begin
            r = m_mask[a-8];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 18; s++) begin
                m_flag[s] = 0; m_prev[s] = 0; m_en[s] = 0;
            end
            for (int g = 0; g < 8; g++) m_mask[g] = '0;
            m_gen = 0; m_off = 0; m_idx = 0;
        end else begin
            bit nf[18];
            bit rq[18];
            bit n_off;
            int n_idx;
            for (int s = 0; s < 18; s++) begin
                rq[s] = m_req(s);
                nf[s] = m_flag[s];
                if (wen && addr >= 3 && addr <= 5 && (s/8) == addr-3 && !wdata[s%8]) nf[s] = 0;
            end
            if (m_off && ack) nf[m_idx] = 0;
            for (int s = 0; s < 18; s++) if (rq[s] && !m_prev[s]) nf[s] = 1;
            n_off = m_off; n_idx = m_idx;
            if (m_off) begin
                if (ack || !m_pend(m_idx)) n_off = 0;
            end else begin
                for (int s = 17; s >= 0; s--) if (m_pend(s)) begin n_off = 1; n_idx = s; end
            end
            if (wen) begin
                if (addr <= 2) begin
                    for (int b = 0; b < 6; b++) m_en[addr*6 + b] = wdata[b];
                    if (addr == 0) m_gen = wdata[7];
                end else if (addr >= 8) m_mask[addr-8] = wdata;
            end
            for (int s = 0; s < 18; s++) begin m_flag[s] = nf[s]; m_prev[s] = rq[s]; end
            m_off = n_off; m_idx = n_idx;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(valid == m_off, "R7 irq_valid vs model", valid, m_off);
            if (m_off) check(idx == 5'(m_idx), "R8 irq_idx vs model", idx, m_idx);
            if (addr <= 2)       check(rdata == m_read(addr), "R3 enable readback", rdata, m_read(addr));
            else if (addr <= 5)  check(rdata == m_read(addr), "R1 flag readback", rdata, m_read(addr));
            else if (addr >= 8)  check(rdata == m_read(addr), "R5 mask readback", rdata, m_read(addr));
            else                 check(rdata == 8'h00, "R11 unused address", rdata, 0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wen = 1'b1;
        @(posedge clk); #1;
        wen = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic pulse_line(int s);
        @(posedge clk); #1; src_line[s] = 1'b1;
        @(posedge clk); #1; src_line[s] = 1'b0;
    endtask

    task automatic do_ack();
        @(posedge clk); #1; ack = 1'b1;
        @(posedge clk); #1; ack = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(valid == 1'b0, "R12 valid after reset", valid, 0);
        rd(0, d); check(d == 8'h00, "R12 enables after reset", d, 0);
        rd(3, d); check(d == 8'h00, "R12 flags after reset", d, 0);
        rd(8, d); check(d == 8'h00, "R12 mask after reset", d, 0);

        wr(0, 8'h20); pulse_line(5); idle(3);
        rd(3, d); check(d == 8'h20, "R1 flag 5 set", d, 8'h20);
        check(valid == 1'b0, "R4 global off blocks", valid, 0);

        wr(0, 8'hA0); idle(3);
        check(valid && idx == 5, "R3 enabled source offered", idx, 5);
        do_ack(); idle(2);
        check(valid == 1'b0, "R9 valid dropped after ack", valid, 0);
        rd(3, d); check(d == 8'h00, "R9 flag cleared by ack", d, 0);

        wr(0, 8'hA4); wr(1, 8'h02);
        @(posedge clk); #1; src_line[2] = 1'b1; src_line[7] = 1'b1;
        @(posedge clk); #1; src_line[2] = 1'b0; src_line[7] = 1'b0;
        idle(3);
        check(valid && idx == 2, "R7 lowest wins", idx, 2);
        rd(3, d); check(d == 8'h84, "R1 two flags", d, 8'h84);
        do_ack(); idle(3);
        check(valid && idx == 7, "R7 next source", idx, 7);
        do_ack(); idle(3);

        pulse_line(4); idle(2); do_ack(); idle(2);
        rd(3, d); check(d == 8'h10, "R9 ack without offer ignored", d, 8'h10);

        wr(0, 8'hB4); idle(2);
        check(valid && idx == 4, "R3 source 4 offered", idx, 4);
        pulse_line(2); idle(3);
        check(valid && idx == 4, "R8 offer held", idx, 4);
        wr(0, 8'hA4); idle(3);
        check(valid && idx == 2, "R8 withdraw and re-pick", idx, 2);
        do_ack(); idle(2);
        wr(3, 8'hEF); rd(3, d); check(d == 8'h00, "R2 write 0 clears", d, 0);
        pulse_line(6); wr(3, 8'hFF); rd(3, d);
        check(d == 8'h40, "R2 write 1 keeps", d, 8'h40);
        wr(3, 8'h00);

        wr(0, 8'h88);
        @(posedge clk); #1 aud_req = 1'b1;
        @(posedge clk); #1 aud_req = 1'b0;
        idle(3);
        check(valid && idx == 3, "R6 shared line", idx, 3);
        do_ack(); idle(2);

        wr(2, 8'h01); wr(10, 8'h04);
        @(posedge clk); #1 grp_evt[19] = 1'b1;
        @(posedge clk); #1 grp_evt[19] = 1'b0;
        idle(3);
        rd(4, d); check(d == 8'h00, "R5 masked event ignored", d, 0);
        @(posedge clk); #1 grp_evt[18] = 1'b1;
        @(posedge clk); #1 grp_evt[18] = 1'b0;
        idle(3);
        rd(4, d); check(d == 8'h10, "R5 unmasked event sets flag", d, 8'h10);
        check(valid && idx == 12, "R5 group source offered", idx, 12);
        do_ack(); idle(2);
        rd(10, d); check(d == 8'h04, "R5 mask readback", d, 8'h04);

        pulse_line(1); idle(2);
        @(posedge clk); #1; addr = 3; wdata = 8'hFD; wen = 1'b1; src_line[1] = 1'b1;
        @(posedge clk); #1; wen = 1'b0; src_line[1] = 1'b0;
        idle(2);
        rd(3, d); check(d == 8'h02, "R10 event beats software clear", d, 8'h02);
        wr(3, 8'hFD); rd(3, d); check(d == 8'h00, "R2 clear source 1", d, 0);

        wr(0, 8'h81); pulse_line(0); idle(3);
        check(valid && idx == 0, "R7 source 0 offered", idx, 0);
        @(posedge clk); #1; ack = 1'b1; src_line[0] = 1'b1;
        @(posedge clk); #1; ack = 1'b0; src_line[0] = 1'b0;
        idle(2);
        rd(3, d); check(d == 8'h01, "R10 event beats ack", d, 8'h01);
        idle(2); do_ack(); idle(2);
        rd(3, d); check(d == 8'h00, "R9 second ack clears", d, 0);

        pulse_line(0); idle(3);
        wr(0, 8'h01); idle(3);
        check(valid == 1'b0, "R4 global off withdraws", valid, 0);
        rd(3, d); check(d == 8'h01, "R4 flag kept", d, 8'h01);
        wr(3, 8'h00);

        wr(6, 8'hFF); rd(6, d); check(d == 8'h00, "R11 addr 6 reads 0", d, 0);
        wr(1, 8'hFF); rd(1, d); check(d == 8'h3F, "R11 unused enable bits", d, 8'h3F);
        wr(0, 8'h7F); rd(0, d); check(d == 8'h3F, "R11 bit 6 of addr 0", d, 8'h3F);
        wr(5, 8'hFF); rd(5, d); check(d == 8'h00, "R11 upper flag bits", d, 0);
        rd(7, d); check(d == 8'h00, "R11 addr 7 reads 0", d, 0);
        wr(1, 8'h00); idle(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule